// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Generator

This block turns single host requests into one asynchronous read or write cycle on an external memory bus. The low address bits and the data share one bus. The block drives an address-latch strobe, a read strobe, a write strobe and one chip select. The upper address bits go out on a separate port and do not change while the cycle runs. The host gives a direction, an address and the write data, and holds the request until a one-cycle done pulse comes back. For a read, the captured data is valid in the same cycle as that pulse.

The block runs on a clock at twice the bus clock and drives the bus clock itself. Each bus clock is therefore two ticks, which lets the write strobe move on falling bus-clock edges. Parameters set the whole cycle shape. They choose multiplexed or separate address/data, a one or two bus-clock latch strobe, the strobe polarity, the read and write strobe start and end counts measured from chip select, and the idle bus clocks between transfers. Counts below the legal minimum are raised to that minimum when the block is built, so a strobe can never overlap the address phase. All pins are registered. Every transfer starts on a rising bus-clock edge.

Top module: `mxb_cycle_gen`

## Requirements
- R1: While reset is held and after it, until a request arrives, `cs_n`, `rd_n` and `wr_n` are high, `ale` is at its inactive level, `ad_oe` is 0 and `done` is 0.
- R2: In multiplexed mode the latch strobe is active for ALE_LEN bus clocks starting where `cs_n` falls. ALE_LEN is 1, or 2 when ALE_TWO is set. It is active high, or active low when ALE_LOW is set.
- R3: In multiplexed mode `ad_out` carries `req_addr[15:0]` with `ad_oe` high from the fall of `cs_n` for ALE_LEN + 0.5 bus clocks. After that a read leaves `ad_oe` low.
- R4: `rd_n` falls RD_DLY bus clocks after `cs_n` falls and stays low for RD_END − RD_DLY + 1 bus clocks. `cs_n` rises on the same edge as `rd_n`. `bus_addr` equals `req_addr` throughout the time `cs_n` is low. `bclk` is high in the first half-clock of each cycle.
- R5: The read delay in use is at least ALE_LEN + 1 in multiplexed mode, and the read end in use is at least the read delay in use. Smaller parameter values are raised to these limits.
- R6: `wr_n` falls WR_DLY + 0.5 bus clocks after `cs_n` falls, while `bclk` is low. It stays low for WR_END − WR_DLY + 1 bus clocks. `cs_n` rises half a bus clock after `wr_n` rises.
- R7: In a write, `ad_oe` stays high for the whole time `cs_n` is low. `ad_out` carries `req_wdata` from the end of the address phase until `cs_n` rises. In multiplexed mode the write delay in use is at least ALE_LEN, and the write end in use is at least that delay.
- R8: `done` pulses for one tick in the first sample where `cs_n` is high again. For a read, `rdata` then holds the value on `ad_in` at the edge where `rd_n` rose.
- R9: When a request is waiting, `cs_n` stays high for exactly IDLE_CYC bus clocks (minimum 1) between two transfers.
- R10: With MUXED = 0, the latch strobe never becomes active, a read never drives `ad_oe`, and `rd_n` may fall together with `cs_n` (read delay 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the bus clock rate |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Transfer request, held until `done` |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | AD_W | Write data |
| rdata | output | AD_W | Captured read data |
| done | output | 1 | One-tick completion pulse |
| bclk | output | 1 | Bus clock |
| cs_n | output | 1 | Chip select, active low |
| ale | output | 1 | Address-latch strobe, polarity set by ALE_LOW |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bus_addr | output | ADDR_W | Non-multiplexed address, stable during the cycle |
| ad_out | output | AD_W | Shared bus drive value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_in | input | AD_W | Shared bus sampled value |

## Verification
The bench runs reads and writes on three builds. The first uses the legal default multiplexed timing. The second uses a two-clock, active-low latch strobe with every delay set to zero, so the clamped values can be told apart from the parameter values. The third uses separate address and data, where there is no address phase. On each cycle the bench records every pin for every half bus clock and checks the first position and the length of each strobe, the enable window and the bus contents. The memory model returns a marker value whenever `rd_n` is high, so a capture one edge early or late is caught. Requests held back-to-back measure the idle gap for each configured count.

// File: rtl/mxb_pkg.sv
package mxb_pkg;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_GAP} seq_st_e;

    // Cycle shape in half bus clocks, counted from the first tick with chip select low.
    typedef struct packed {
        logic [7:0] ale_h;    // latch strobe active while h < ale_h
        logic [7:0] addr_h;   // address on the shared bus while h < addr_h
        logic [7:0] rd_on;
        logic [7:0] rd_off;   // also the end of a read cycle
        logic [7:0] wr_on;
        logic [7:0] wr_off;
        logic [7:0] wcs_off;  // end of a write cycle
        logic [7:0] gap_h;    // idle ticks between cycles
    } tim_t;

    typedef struct packed {
        logic cs;
        logic ale;
        logic rd;
        logic wr;
        logic oe;
        logic dsel;  // 1: data on shared bus, 0: address
    } pins_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Clamps the wait-state counts to their legal floors and turns them into tick limits.
    function automatic tim_t calc_tim(input int mux, input int ale2, input int rdly,
                                      input int rend, input int wdly, input int wend,
                                      input int idle);
        tim_t t;
        int   al;
        int   rd_d;
        int   rd_e;
        int   wr_d;
        int   wr_e;
        t    = '0;
        al   = (ale2 != 0) ? 2 : 1;
        rd_d = imax(rdly, (mux != 0) ? al + 1 : 0);
        rd_e = imax(rend, rd_d);
        wr_d = imax(wdly, (mux != 0) ? al : 0);
        wr_e = imax(wend, wr_d);
        t.ale_h   = 8'((mux != 0) ? 2 * al : 0);
        t.addr_h  = 8'((mux != 0) ? 2 * al + 1 : 0);
        t.rd_on   = 8'(2 * rd_d);
        t.rd_off  = 8'(2 * (rd_e + 1));
        t.wr_on   = 8'(2 * wr_d + 1);
        t.wr_off  = 8'(2 * (wr_e + 1) + 1);
        t.wcs_off = 8'(2 * (wr_e + 1) + 2);
        t.gap_h   = 8'(2 * imax(idle, 1));
        return t;
    endfunction

    function automatic pins_t decode(input tim_t t, input logic [7:0] h, input logic wr);
        pins_t p;
        p.ale  = (h < t.ale_h);
        p.cs   = wr ? (h < t.wcs_off) : (h < t.rd_off);
        p.rd   = !wr && (h >= t.rd_on) && (h < t.rd_off);
        p.wr   = wr && (h >= t.wr_on) && (h < t.wr_off);
        p.dsel = (h >= t.addr_h);
        p.oe   = wr ? p.cs : (h < t.addr_h);
        return p;
    endfunction

endpackage

// File: rtl/mxb_seq.sv
module mxb_seq
    import mxb_pkg::*;
#(
    parameter tim_t TIM = '0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       req_wr,
    output logic       run,
    output logic [7:0] h,
    output logic       cyc_wr,
    output logic       start,
    output logic       fin,
    output logic       ph
);
    seq_st_e    st;
    logic [7:0] g;
    logic [7:0] last;
    logic       ready;

    assign last  = cyc_wr ? TIM.wcs_off : TIM.rd_off;
    assign run   = (st == ST_RUN);
    assign fin   = run && (h == last);
    assign ready = (st == ST_IDLE) || ((st == ST_GAP) && (g == TIM.gap_h - 8'd2));
    // ph high now means the next tick opens a rising bus-clock half
    assign start = ready && req && ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            h      <= '0;
            g      <= '0;
            ph     <= 1'b0;
            cyc_wr <= 1'b0;
        end else begin
            ph <= ~ph;
            if (start) begin
                st     <= ST_RUN;
                h      <= '0;
                cyc_wr <= req_wr;
            end else begin
                case (st)
                    ST_RUN: begin
                        if (fin) begin
                            st <= ST_GAP;
                            g  <= '0;
                        end else begin
                            h <= h + 8'd1;
                        end
                    end
                    ST_GAP: begin
                        if (g == TIM.gap_h - 8'd2) st <= ST_IDLE;
                        else                       g  <= g + 8'd1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // every cycle begins on a rising bus-clock half
    assert_start_phase_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> !ph);

endmodule

// File: rtl/mxb_pins.sv
module mxb_pins
    import mxb_pkg::*;
#(
    parameter tim_t TIM     = '0,
    parameter int   ADDR_W  = 24,
    parameter int   AD_W    = 16,
    parameter bit   ALE_LOW = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              run,
    input  logic [7:0]        h,
    input  logic              cyc_wr,
    input  logic              ph,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [AD_W-1:0]   req_wdata,
    output logic              bclk,
    output logic              cs_n,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [AD_W-1:0]   ad_out,
    output logic              ad_oe
);
    logic [ADDR_W-1:0] addr_q;
    logic [AD_W-1:0]   wdata_q;
    pins_t             p;

    assign p = run ? decode(TIM, h, cyc_wr) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (start) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk     <= 1'b0;
            cs_n     <= 1'b1;
            ale      <= ALE_LOW;
            rd_n     <= 1'b1;
            wr_n     <= 1'b1;
            bus_addr <= '0;
            ad_out   <= '0;
            ad_oe    <= 1'b0;
        end else begin
            bclk     <= ~ph;
            cs_n     <= ~p.cs;
            ale      <= p.ale ^ ALE_LOW;
            rd_n     <= ~p.rd;
            wr_n     <= ~p.wr;
            bus_addr <= addr_q;
            ad_out   <= p.oe ? (p.dsel ? wdata_q : addr_q[AD_W-1:0]) : '0;
            ad_oe    <= p.oe;
        end
    end

    assert_strobe_in_cs_R4: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> !cs_n);
    assert_one_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));
    assert_rd_bus_free_R5: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe);
    assert_ale_drives_R3: assert property (@(posedge clk) disable iff (rst)
        (ale != ALE_LOW) |-> ad_oe);
    assert_cs_rd_rise_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_n) |-> cs_n);
    assert_wr_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_n) |-> !bclk);
    assert_addr_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && $past(!cs_n)) |-> $stable(bus_addr));

endmodule

// File: rtl/mxb_capture.sv
module mxb_capture #(
    parameter int AD_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fin,
    input  logic            cyc_wr,
    input  logic [AD_W-1:0] ad_in,
    output logic [AD_W-1:0] rdata,
    output logic            done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            done  <= 1'b0;
        end else begin
            done <= fin;
            if (fin && !cyc_wr) rdata <= ad_in;
        end
    end

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/mxb_cycle_gen.sv
module mxb_cycle_gen
    import mxb_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int AD_W     = 16,
    parameter int MUXED    = 1,
    parameter int ALE_TWO  = 0,
    parameter bit ALE_LOW  = 1'b0,
    parameter int RD_DLY   = 2,
    parameter int RD_END   = 3,
    parameter int WR_DLY   = 1,
    parameter int WR_END   = 2,
    parameter int IDLE_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [AD_W-1:0]   req_wdata,
    output logic [AD_W-1:0]   rdata,
    output logic              done,
    output logic              bclk,
    output logic              cs_n,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [AD_W-1:0]   ad_out,
    output logic              ad_oe,
    input  logic [AD_W-1:0]   ad_in
);
    localparam tim_t TIM = calc_tim(MUXED, ALE_TWO, RD_DLY, RD_END, WR_DLY, WR_END, IDLE_CYC);

    logic       run;
    logic [7:0] h;
    logic       cyc_wr;
    logic       start;
    logic       fin;
    logic       ph;

    mxb_seq #(.TIM(TIM)) u_seq (
        .clk(clk), .rst(rst), .req(req), .req_wr(req_wr),
        .run(run), .h(h), .cyc_wr(cyc_wr), .start(start), .fin(fin), .ph(ph)
    );

    mxb_pins #(.TIM(TIM), .ADDR_W(ADDR_W), .AD_W(AD_W), .ALE_LOW(ALE_LOW)) u_pins (
        .clk(clk), .rst(rst), .start(start), .run(run), .h(h), .cyc_wr(cyc_wr), .ph(ph),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .bclk(bclk), .cs_n(cs_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .bus_addr(bus_addr), .ad_out(ad_out), .ad_oe(ad_oe)
    );

    mxb_capture #(.AD_W(AD_W)) u_cap (
        .clk(clk), .rst(rst), .fin(fin), .cyc_wr(cyc_wr), .ad_in(ad_in),
        .rdata(rdata), .done(done)
    );

endmodule

// File: tb/mxb_cycle_gen_bench.sv
module mxb_cycle_gen_bench;
    logic clk = 1'b0;
    always #10 clk = ~clk;
    logic rst;

    logic [2:0]  req, req_wr, done_w, bclk_w, cs_n_w, ale_w, rd_n_w, wr_n_w, oe_w;
    logic [23:0] addr [3];
    logic [23:0] baddr_w [3];
    logic [15:0] wd [3];
    logic [15:0] mem [3];
    logic [15:0] rdata_w [3];
    logic [15:0] ad_w [3];
    logic [15:0] adin_w [3];
    logic [2:0]  ale_low = 3'b010;

    int nvec = 0, nbad = 0;
    bit finished = 0;

    // memory model: real data only while the read strobe is low
    assign adin_w[0] = !rd_n_w[0] ? mem[0] : 16'h0BAD;
    assign adin_w[1] = !rd_n_w[1] ? mem[1] : 16'h0BAD;
    assign adin_w[2] = !rd_n_w[2] ? mem[2] : 16'h0BAD;

    mxb_cycle_gen u_mxb_cycle_gen (
        .clk(clk), .rst(rst), .req(req[0]), .req_wr(req_wr[0]), .req_addr(addr[0]),
        .req_wdata(wd[0]), .rdata(rdata_w[0]), .done(done_w[0]), .bclk(bclk_w[0]),
        .cs_n(cs_n_w[0]), .ale(ale_w[0]), .rd_n(rd_n_w[0]), .wr_n(wr_n_w[0]),
        .bus_addr(baddr_w[0]), .ad_out(ad_w[0]), .ad_oe(oe_w[0]), .ad_in(adin_w[0]));

    mxb_cycle_gen #(.ALE_TWO(1), .ALE_LOW(1'b1), .RD_DLY(0), .RD_END(0), .WR_DLY(0),
                    .WR_END(0), .IDLE_CYC(1)) u_mxb_cycle_gen_clamp (
        .clk(clk), .rst(rst), .req(req[1]), .req_wr(req_wr[1]), .req_addr(addr[1]),
        .req_wdata(wd[1]), .rdata(rdata_w[1]), .done(done_w[1]), .bclk(bclk_w[1]),
        .cs_n(cs_n_w[1]), .ale(ale_w[1]), .rd_n(rd_n_w[1]), .wr_n(wr_n_w[1]),
        .bus_addr(baddr_w[1]), .ad_out(ad_w[1]), .ad_oe(oe_w[1]), .ad_in(adin_w[1]));

    mxb_cycle_gen #(.MUXED(0), .RD_DLY(0), .RD_END(1), .WR_DLY(0), .WR_END(1),
                    .IDLE_CYC(2)) u_mxb_cycle_gen_nm (
        .clk(clk), .rst(rst), .req(req[2]), .req_wr(req_wr[2]), .req_addr(addr[2]),
        .req_wdata(wd[2]), .rdata(rdata_w[2]), .done(done_w[2]), .bclk(bclk_w[2]),
        .cs_n(cs_n_w[2]), .ale(ale_w[2]), .rd_n(rd_n_w[2]), .wr_n(wr_n_w[2]),
        .bus_addr(baddr_w[2]), .ad_out(ad_w[2]), .ad_oe(oe_w[2]), .ad_in(adin_w[2]));

    // per-half-clock record of one cycle, index 0 = first sample with cs_n low
    logic        csr [64], aler [64], rdr [64], wrr [64], oer [64], bckr [64];
    logic [15:0] adr [64];
    logic [23:0] bar [64];
    int          nrec, done_at;
    logic [15:0] rd_val;

    task automatic chk(input bit ok, input string tg, input string what,
                       input longint act, input longint exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tg, what, act, exp);
        end
    endtask

    function automatic void span(input logic v [64], input int n, output int f,
                                 output int c, output bit contig);
        int last;
        f = -1; c = 0; last = -1;
        for (int i = 0; i < n; i++) begin
            if (v[i]) begin
                if (f < 0) f = i;
                last = i;
                c++;
            end
        end
        contig = (c == 0) || (last - f + 1 == c);
    endfunction

    task automatic chk_span(input string tg, input string nm, input logic v [64],
                            input int ef, input int ec);
        int f, c; bit ok;
        span(v, nrec, f, c, ok);
        nvec++;
        if (f != ef || c != ec || !ok) begin
            nbad++;
            $display("FAIL %s %s: first=%0d len=%0d expected first=%0d len=%0d",
                     tg, nm, f, c, ef, ec);
        end
    endtask

    task automatic do_cycle(input int k, input bit w, input logic [23:0] a,
                            input logic [15:0] d, input bit keep);
        int idx, guard;
        @(negedge clk);
        req_wr[k] = w; addr[k] = a; wd[k] = d; req[k] = 1'b1;
        idx = -1; done_at = -1; guard = 0;
        while (done_at < 0 && guard < 300) begin
            @(negedge clk);
            guard++;
            if (idx < 0 && !cs_n_w[k]) idx = 0;
            if (idx >= 0 && idx < 64) begin
                csr[idx]  = !cs_n_w[k];
                aler[idx] = ale_w[k] ^ ale_low[k];
                rdr[idx]  = !rd_n_w[k];
                wrr[idx]  = !wr_n_w[k];
                oer[idx]  = oe_w[k];
                bckr[idx] = bclk_w[k];
                adr[idx]  = ad_w[k];
                bar[idx]  = baddr_w[k];
            end
            if (idx >= 0 && done_w[k]) begin
                done_at = idx;
                rd_val  = rdata_w[k];
            end
            if (idx >= 0) idx++;
        end
        if (!keep) req[k] = 1'b0;
        nrec = (done_at < 0) ? 0 : ((done_at + 1 > 64) ? 64 : done_at + 1);
        chk(done_at >= 0, "R8", "done seen", done_at, 1);
    endtask

    task automatic t_reset();
        for (int k = 0; k < 3; k++) begin
            chk(cs_n_w[k] && rd_n_w[k] && wr_n_w[k], "R1", "strobes idle",
                {cs_n_w[k], rd_n_w[k], wr_n_w[k]}, 3'b111);
            chk(!oe_w[k] && !done_w[k] && (ale_w[k] == ale_low[k]), "R1", "oe/done/ale idle",
                {oe_w[k], done_w[k], ale_w[k]}, {2'b00, ale_low[k]});
        end
    endtask

    task automatic t_read(input int k, input string tg, input int cs_l, input int ale_l,
                          input int oe_l, input int rd_f, input int rd_l);
        logic [23:0] a = 24'h5A0000 + 24'(k * 24'h1357) + 24'h00C3A5;
        mem[k] = 16'h7E10 + 16'(k);
        do_cycle(k, 1'b0, a, 16'h0, 1'b0);
        chk_span({tg, "/R4"}, "cs", csr, 0, cs_l);
        chk_span({tg, "/R2"}, "ale", aler, (ale_l > 0) ? 0 : -1, ale_l);
        chk_span({tg, "/R3"}, "ad_oe", oer, (oe_l > 0) ? 0 : -1, oe_l);
        chk_span({tg, "/R4"}, "rd", rdr, rd_f, rd_l);
        chk_span({tg, "/R4"}, "wr", wrr, -1, 0);
        if (oe_l > 0) chk(adr[0] == a[15:0] && adr[oe_l-1] == a[15:0], {tg, "/R3"},
                          "address on bus", adr[oe_l-1], a[15:0]);
        chk(bar[0] == a && bar[cs_l-1] == a, {tg, "/R4"}, "bus_addr", bar[cs_l-1], a);
        chk(bckr[0] == 1'b1, {tg, "/R4"}, "bclk at start", bckr[0], 1);
        chk(done_at == cs_l, {tg, "/R8"}, "done position", done_at, cs_l);
        chk(rd_val == mem[k], {tg, "/R8"}, "rdata", rd_val, mem[k]);
    endtask

    task automatic t_write(input int k, input string tg, input int cs_l, input int ale_l,
                           input int addr_h, input int wr_f, input int wr_l);
        logic [23:0] a = 24'h3C0000 + 24'(k * 24'h0F0F) + 24'h0081E7;
        logic [15:0] d = 16'hA5C0 + 16'(k);
        bit dat_ok = 1;
        do_cycle(k, 1'b1, a, d, 1'b0);
        chk_span({tg, "/R6"}, "cs", csr, 0, cs_l);
        chk_span({tg, "/R2"}, "ale", aler, (ale_l > 0) ? 0 : -1, ale_l);
        chk_span({tg, "/R7"}, "ad_oe", oer, 0, cs_l);
        chk_span({tg, "/R6"}, "wr", wrr, wr_f, wr_l);
        chk_span({tg, "/R6"}, "rd", rdr, -1, 0);
        for (int i = 0; i < cs_l; i++)
            if (adr[i] != ((i < addr_h) ? a[15:0] : d)) dat_ok = 0;
        chk(dat_ok, {tg, "/R7"}, "address then data on bus", adr[cs_l-1], d);
        chk(bckr[wr_f] == 1'b0, {tg, "/R6"}, "bclk at wr fall", bckr[wr_f], 0);
        chk(done_at == cs_l, {tg, "/R8"}, "done position", done_at, cs_l);
    endtask

    task automatic t_gap(input int k, input string tg, input int exp);
        int gap = 1, guard = 0;
        mem[k] = 16'h1111;
        do_cycle(k, 1'b0, 24'h000111, 16'h0, 1'b1);
        while (cs_n_w[k] && guard < 200) begin
            @(negedge clk);
            if (cs_n_w[k]) gap++;
            guard++;
        end
        chk(gap == exp, {tg, "/R9"}, "idle gap ticks", gap, exp);
        guard = 0;
        while (!done_w[k] && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        req[k] = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    initial begin
        req = '0; req_wr = '0;
        for (int k = 0; k < 3; k++) begin
            addr[k] = '0; wd[k] = '0; mem[k] = '0;
        end
        rst = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        // default multiplexed timing
        t_read (0, "R2", 8, 2, 3, 4, 4);
        t_write(0, "R6", 8, 2, 3, 3, 4);
        // below-minimum counts, two-clock active-low latch strobe
        t_read (1, "R5", 8, 4, 5, 6, 2);
        t_write(1, "R7", 8, 4, 5, 5, 2);
        // separate address and data
        t_read (2, "R10", 4, 0, 0, 0, 4);
        t_write(2, "R10", 6, 0, 0, 1, 4);
        t_gap(0, "R9", 6);
        t_gap(1, "R9", 2);
        t_gap(2, "R9", 4);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nvec++; nbad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

endmodule